// File: doc/BRIEF.md
# Switchable Mirroring Scratchpad Decoder

This block sits on a 16-bit CPU bus and decides whether an access belongs to a small on-board scratch RAM. That RAM lives in a 1 KB window at the base of an 8 KB device page. The rest of the page belongs to other peripherals: video, sound, speech and graphics-ROM ports. The decoder must never claim those addresses. The bus is word-wide, so address bit 0 is ignored and the RAM is organised as 512 words indexed by address bits 9 down to 1.

The block has two behaviours, selected by a mode input. With the mode input high, the block runs in mirrored mode. Only 256 bytes are addressed, and address bits 9 and 8 are dropped, so the four 256-byte quarters of the window alias onto one another. With the mode input low, the block runs in linear mode. Those two bits reach the RAM, and the four quarters become distinct storage.

On the board the mode input is held high by a pull-up until software drives it low. For that reason the block always leaves reset in mirrored mode. The mode input is captured in a register, so a change takes effect at the next clock edge and never partway through a bus cycle. The chip select and write enable are combinational on the address and the strobes.

Top module: `scratch_decoder`

## Requirements
- R1: `ram_cs` is high exactly when `cpu_addr` lies in 0x8000..0x83FF and `cpu_rd` or `cpu_wr` is high.
- R2: `ram_cs` and `ram_we` stay low for any address in 0x8400..0x9FFF, and for any address outside the 1 KB window.
- R3: In mirrored mode (registered mode = 1), `ram_addr[8:7]` is 0 and `ram_addr[6:0]` equals `cpu_addr[7:1]`, so 0x8000, 0x8100, 0x8200 and 0x8300 select the same word.
- R4: In linear mode (registered mode = 0), `ram_addr` equals `cpu_addr[9:1]`.
- R5: The mode used for decoding is the value `mode_mirror` had at the previous rising clock edge. A change on the input is not visible before that edge.
- R6: While `rst` is high, and until the first rising edge after it falls, the decoder is in mirrored mode whatever `mode_mirror` is.
- R7: `cpu_addr[0]` has no effect on `ram_addr` or `ram_cs`.
- R8: `ram_we` is high only when `ram_cs` and `cpu_wr` are both high. A read selects the RAM with `ram_we` low.
- R9: With neither strobe high, `ram_cs` is low even inside the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| mode_mirror | input | 1 | 1 = mirrored 256-byte mode, 0 = linear 1 KB mode |
| ram_addr | output | 9 | Word address to the RAM |
| ram_cs | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write enable |

## Verification
Select, write enable and RAM address follow the address and strobes in the same cycle. A change on the mode input only reaches `ram_addr` after the next rising edge.

The bench drives every input at the falling edge and samples 2 ns after the following rising edge. By then the registered mode has taken its new value and the combinational outputs have settled. The mode-lag and reset checks also sample once before that edge, to confirm the old mode is still in force there.

// File: rtl/scratch_pkg.sv
package scratch_pkg;
  typedef enum logic {
    MODE_LINEAR = 1'b0,
    MODE_MIRROR = 1'b1
  } scratch_mode_e;
endpackage

// File: rtl/scratch_window.sv
module scratch_window #(
  parameter int ADDR_W = 16,
  parameter int WIN_LOG2 = 10,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic              hit
);
  localparam int TAG_W = ADDR_W - WIN_LOG2;
  localparam logic [TAG_W-1:0] BASE_TAG = WIN_BASE[ADDR_W-1:WIN_LOG2];

  logic in_window;

  always_comb begin
    in_window = (cpu_addr[ADDR_W-1:WIN_LOG2] == BASE_TAG);
    hit       = in_window && (cpu_rd || cpu_wr);
  end

  AST_NO_FOREIGN: assert property (@(posedge clk) disable iff (rst)
    ((cpu_addr >= 16'h8400) && (cpu_addr <= 16'h9FFF)) |-> !hit); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!cpu_rd && !cpu_wr) |-> !hit); // R9
endmodule

// File: rtl/scratch_mode_reg.sv
module scratch_mode_reg
  import scratch_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_in,
  output scratch_mode_e mode_q
);
  logic past_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= MODE_MIRROR;
      past_valid <= 1'b0;
    end else begin
      mode_q     <= scratch_mode_e'(mode_in);
      past_valid <= 1'b1;
    end
  end

  AST_MODE_LAG: assert property (@(posedge clk) disable iff (rst)
    past_valid |-> (mode_q == scratch_mode_e'($past(mode_in)))); // R5
  AST_RESET_MIRROR: assert property (@(posedge clk)
    $past(rst) |-> (mode_q == MODE_MIRROR)); // R6
endmodule

// File: rtl/scratch_addr_map.sv
module scratch_addr_map
  import scratch_pkg::*;
#(
  parameter int WIN_LOG2 = 10,
  parameter int SEG_LOG2 = 8,
  parameter int WORD_LOG2 = 1,
  localparam int RAM_AW = WIN_LOG2 - WORD_LOG2
) (
  input  logic [RAM_AW-1:0] word_idx,
  input  scratch_mode_e     mode,
  output logic [RAM_AW-1:0] ram_addr
);
  for (genvar i = 0; i < RAM_AW; i++) begin : g_bit
    if (i + WORD_LOG2 < SEG_LOG2) begin : g_pass
      assign ram_addr[i] = word_idx[i];
    end else begin : g_fold
      assign ram_addr[i] = word_idx[i] & (mode == MODE_LINEAR);
    end
  end
endmodule

// File: rtl/scratch_decoder.sv
module scratch_decoder
  import scratch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WIN_LOG2 = 10,
  parameter int SEG_LOG2 = 8,
  parameter int WORD_LOG2 = 1,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h8000,
  localparam int RAM_AW = WIN_LOG2 - WORD_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic              mode_mirror,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_cs,
  output logic              ram_we
);
  scratch_mode_e mode_q;
  logic          hit;

  scratch_mode_reg u_mode (
    .clk     (clk),
    .rst     (rst),
    .mode_in (mode_mirror),
    .mode_q  (mode_q)
  );

  scratch_window #(
    .ADDR_W   (ADDR_W),
    .WIN_LOG2 (WIN_LOG2),
    .WIN_BASE (WIN_BASE)
  ) u_win (
    .clk      (clk),
    .rst      (rst),
    .cpu_addr (cpu_addr),
    .cpu_rd   (cpu_rd),
    .cpu_wr   (cpu_wr),
    .hit      (hit)
  );

  scratch_addr_map #(
    .WIN_LOG2  (WIN_LOG2),
    .SEG_LOG2  (SEG_LOG2),
    .WORD_LOG2 (WORD_LOG2)
  ) u_map (
    .word_idx (cpu_addr[WIN_LOG2-1:WORD_LOG2]),
    .mode     (mode_q),
    .ram_addr (ram_addr)
  );

  always_comb begin
    ram_cs = hit;
    ram_we = hit && cpu_wr;
  end

  AST_CS_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    ram_cs |-> (cpu_addr >= 16'h8000 && cpu_addr <= 16'h83FF)); // R1
  AST_MIRROR_FOLD: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_MIRROR) |-> (ram_addr[8:7] == 2'b00)); // R3
  AST_LINEAR_PASS: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_LINEAR) |-> (ram_addr == cpu_addr[9:1])); // R4
  AST_WE_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (ram_cs && cpu_wr)); // R8
endmodule

// File: tb/tb_scratch_decoder.sv
module tb_scratch_decoder;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] cpu_addr;
  logic        cpu_rd, cpu_wr, mode_mirror;
  logic [8:0]  ram_addr;
  logic        ram_cs, ram_we;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  scratch_decoder dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .mode_mirror(mode_mirror),
    .ram_addr(ram_addr), .ram_cs(ram_cs), .ram_we(ram_we)
  );

  // {addr, rd, wr, mode, exp_cs, exp_we, exp_addr}
  localparam logic [29:0] VEC [16] = '{
    {16'h8000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 9'h000},
    {16'h8302, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 9'h001},
    {16'h8102, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 9'h001},
    {16'h83FE, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 9'h07F},
    {16'h8302, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 9'h181},
    {16'h8102, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 9'h081},
    {16'h83FE, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 9'h1FF},
    {16'h8000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 9'h000},
    {16'h8400, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 9'h000},
    {16'h8800, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 9'h000},
    {16'h9FFE, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000},
    {16'h7FFE, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000},
    {16'hA000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 9'h000},
    {16'h0300, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000},
    {16'h8201, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 9'h100},
    {16'h8200, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (addr=%h t=%0t)", req, act, exp, cpu_addr, $time);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic r, input logic w, input logic m);
    @(negedge clk);
    cpu_addr = a; cpu_rd = r; cpu_wr = w; mode_mirror = m;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; cpu_addr = 16'h0000; cpu_rd = 1'b0; cpu_wr = 1'b0; mode_mirror = 1'b0;
    // R6: in reset with mode input low, still mirrored
    drive(16'h8302, 1'b1, 1'b0, 1'b0);
    @(posedge clk); #2;
    chk("R6 reset mirror", {7'd0, ram_addr}, 16'h0001);
    @(negedge clk); rst = 1'b0; #2;
    chk("R6 mirror before first edge", {7'd0, ram_addr}, 16'h0001);
    @(posedge clk); #2;
    chk("R5 linear after edge", {7'd0, ram_addr}, 16'h0181);
    // R5: mode change not visible before the edge
    @(negedge clk); mode_mirror = 1'b1; #2;
    chk("R5 old mode held", {7'd0, ram_addr}, 16'h0181);
    @(posedge clk); #2;
    chk("R5 new mode taken", {7'd0, ram_addr}, 16'h0001);

    // table walk: R1 R2 R3 R4 R7 R8 R9
    for (int i = 0; i < 16; i++) begin
      drive(VEC[i][29:14], VEC[i][13], VEC[i][12], VEC[i][11]);
      @(posedge clk); #2;
      chk("R1/R2/R9 cs", {15'd0, ram_cs}, {15'd0, VEC[i][10]});
      chk("R8 we", {15'd0, ram_we}, {15'd0, VEC[i][9]});
      if (VEC[i][10])
        chk(VEC[i][11] ? "R3 mirror addr" : "R4/R7 linear addr", {7'd0, ram_addr}, {7'd0, VEC[i][8:0]});
    end

    // R7: odd address in mirrored mode maps like the even one
    drive(16'h83FF, 1'b0, 1'b1, 1'b1);
    @(posedge clk); #2;
    chk("R7 A0 ignored addr", {7'd0, ram_addr}, 16'h007F);
    chk("R7 A0 ignored cs", {15'd0, ram_cs}, 16'h0001);

    // R2: last byte of window vs first foreign byte
    drive(16'h83FF, 1'b1, 1'b0, 1'b0);
    @(posedge clk); #2;
    chk("R1 top of window", {15'd0, ram_cs}, 16'h0001);
    drive(16'h8401, 1'b0, 1'b1, 1'b0);
    @(posedge clk); #2;
    chk("R2 just above window", {14'd0, ram_cs, ram_we}, 16'h0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule